// File: doc/BRIEF.md
# PCI Posted Write Buffer

This block sits between a PCI target and the local memory bus. Write data phases arriving from a PCI master are latched into a small posting store. Each phase completes on the PCI bus as soon as it is latched, so the master never waits for local memory unless the store is full. The stored entries are then replayed towards local memory one at a time. Each replay is a single-beat write carrying the entry's full address, data word and byte enables. This holds even when the PCI side delivered them as a burst.

Read paths in both directions ask the block for a flush before they proceed. While a flush is requested, new posting is held off with wait states. A flush-done indication is raised once nothing is stored and no internal write is outstanding. An internal conflict reported during a burst ends that burst with a target abort. Phases latched before the conflict remain valid and are still written. A sticky status flag records that an abort was signalled, and it is cleared by writing one to it.

Top module: `pci_post_wbuf`

## Requirements
- R1: A data phase is accepted in a cycle where `pw_frame`, `pw_valid` and `pw_ready` are all high. Each accepted phase with at least one byte enable set later appears as exactly one internal write. That write carries the same address, data and byte enables. Enable bit i qualifies data bits 8i+7 down to 8i.
- R2: Internal writes are issued in the order in which their phases were accepted, one entry per `iw_req`/`iw_ack` handshake.
- R3: Once `iw_req` is raised, it stays high with unchanged `iw_addr`, `iw_data` and `iw_be` until a cycle in which `iw_ack` is high.
- R4: A phase with byte enables 4'b0000 is accepted (wait-free) but never produces an internal write.
- R5: The store holds BUF_BYTES/4 entries, plus one entry held in the outgoing write. With no acknowledges, exactly BUF_BYTES/4+1 phases are accepted. Further phases see `pw_ready` low until an entry drains.
- R6: `flush_done` is high only while `flush_req` is high, nothing is stored and `iw_req` is low.
- R7: While `flush_req` is high, `pw_ready` is low.
- R8: A phase offered while `int_conflict` is high is not accepted and raises `pw_abort` in that cycle. Every later phase of the same frame is also aborted, until `pw_frame` falls. Phases accepted earlier in the frame are still written.
- R9: A cycle with `pw_abort` high sets `ta_status` from the next cycle. The flag then stays set until cleared.
- R10: `ta_clear` high clears `ta_status` in the next cycle, unless `pw_abort` is high in the same cycle, in which case the flag stays set.
- R11: After reset, `iw_req`, `ta_status` and `flush_done` are low. An idle buffer with `pw_frame` high shows `pw_ready` high.
- R12: A held flush request sees `flush_done` rise once all accepted entries have been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pw_frame | input | 1 | PCI write transaction in progress |
| pw_valid | input | 1 | PCI data phase offered |
| pw_addr | input | 32 | Byte address of the data phase |
| pw_data | input | 32 | Write data of the data phase |
| pw_be | input | 4 | Active-high byte enables of the data phase |
| pw_ready | output | 1 | Phase accepted this cycle (low inserts a wait state) |
| pw_abort | output | 1 | Phase terminated with target abort |
| int_conflict | input | 1 | Internal conflict forcing an abort |
| iw_req | output | 1 | Internal single-beat write request |
| iw_addr | output | 32 | Internal write address |
| iw_data | output | 32 | Internal write data |
| iw_be | output | 4 | Internal write byte enables |
| iw_ack | input | 1 | Internal write accepted |
| flush_req | input | 1 | Read path asks for all posted writes to drain |
| flush_done | output | 1 | All posted writes drained |
| ta_status | output | 1 | Sticky target-abort-signalled flag |
| ta_clear | input | 1 | Write-one-to-clear for the status flag |

## Verification
The bench builds the block with BUF_BYTES set to 16, so the store has four entries. With acknowledges withheld, the full condition is then reached after only five phases. The exact count of accepted phases and the wait states that follow can be checked within a few cycles. The same small depth lets a flush wait on a stalled drain. Abort, clear-versus-set collisions, zero-enable drops and alternating acknowledges all run against a queue of expected writes.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam int PWB_ADDR_W = 32;
    localparam int PWB_DATA_W = 32;
    localparam int PWB_LANES  = PWB_DATA_W / 8;

    typedef struct packed {
        logic [PWB_ADDR_W-1:0] addr;
        logic [PWB_DATA_W-1:0] data;
        logic [PWB_LANES-1:0]  be;
    } pwb_entry_t;

    function automatic int entries_for(input int nbytes);
        return nbytes / PWB_LANES;
    endfunction

    function automatic logic any_lane(input logic [PWB_LANES-1:0] be);
        return |be;
    endfunction

endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo
    import pwb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  pwb_entry_t wr_entry,
    input  logic       pop,
    output pwb_entry_t rd_entry,
    output logic       empty,
    output logic       full
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0] wr_ptr;
    logic [AW:0] rd_ptr;
    pwb_entry_t  slots [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && wr_ptr[AW-1:0] == AW'(i)) begin
                    slots[i] <= wr_entry;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign rd_entry = slots[rd_ptr[AW-1:0]];
    assign empty    = (wr_ptr == rd_ptr);
    assign full     = (wr_ptr[AW] != rd_ptr[AW]) &&
                      (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);

endmodule

// File: rtl/pwb_target.sv
module pwb_target
    import pwb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pw_frame,
    input  logic                 pw_valid,
    input  logic [PWB_LANES-1:0] pw_be,
    input  logic                 int_conflict,
    input  logic                 store_full,
    input  logic                 flush_req,
    input  logic                 ta_clear,
    output logic                 pw_ready,
    output logic                 pw_abort,
    output logic                 push,
    output logic                 ta_status
);
    logic abort_q;
    logic ta_q;

    assign pw_abort = pw_frame && pw_valid && (int_conflict || abort_q);
    assign pw_ready = pw_frame && !abort_q && !int_conflict &&
                      !store_full && !flush_req;
    assign push     = pw_valid && pw_ready && any_lane(pw_be);

    always_ff @(posedge clk) begin
        if (rst) begin
            abort_q <= 1'b0;
        end else if (!pw_frame) begin
            abort_q <= 1'b0;
        end else if (pw_abort) begin
            abort_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ta_q <= 1'b0;
        end else if (pw_abort) begin
            ta_q <= 1'b1;
        end else if (ta_clear) begin
            ta_q <= 1'b0;
        end
    end

    assign ta_status = ta_q;

endmodule

// File: rtl/pwb_drain.sv
module pwb_drain
    import pwb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  pwb_entry_t            head,
    input  logic                  empty,
    input  logic                  iw_ack,
    output logic                  pop,
    output logic                  iw_req,
    output logic [PWB_ADDR_W-1:0] iw_addr,
    output logic [PWB_DATA_W-1:0] iw_data,
    output logic [PWB_LANES-1:0]  iw_be
);
    pwb_entry_t beat_q;
    logic       req_q;

    assign pop = !empty && (!req_q || iw_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else if (pop) begin
            req_q <= 1'b1;
        end else if (iw_ack) begin
            req_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (pop) begin
            beat_q <= head;
        end
    end

    assign iw_req  = req_q;
    assign iw_addr = beat_q.addr;
    assign iw_data = beat_q.data;
    assign iw_be   = beat_q.be;

endmodule

// File: rtl/pci_post_wbuf.sv
module pci_post_wbuf
    import pwb_pkg::*;
#(
    parameter int BUF_BYTES = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pw_frame,
    input  logic                  pw_valid,
    input  logic [PWB_ADDR_W-1:0] pw_addr,
    input  logic [PWB_DATA_W-1:0] pw_data,
    input  logic [PWB_LANES-1:0]  pw_be,
    output logic                  pw_ready,
    output logic                  pw_abort,
    input  logic                  int_conflict,
    output logic                  iw_req,
    output logic [PWB_ADDR_W-1:0] iw_addr,
    output logic [PWB_DATA_W-1:0] iw_data,
    output logic [PWB_LANES-1:0]  iw_be,
    input  logic                  iw_ack,
    input  logic                  flush_req,
    output logic                  flush_done,
    output logic                  ta_status,
    input  logic                  ta_clear
);
    localparam int DEPTH = entries_for(BUF_BYTES);

    logic       push;
    logic       pop;
    logic       empty;
    logic       full;
    pwb_entry_t in_entry;
    pwb_entry_t head;

    assign in_entry = '{addr: pw_addr, data: pw_data, be: pw_be};

    pwb_target u_target (
        .clk          (clk),
        .rst          (rst),
        .pw_frame     (pw_frame),
        .pw_valid     (pw_valid),
        .pw_be        (pw_be),
        .int_conflict (int_conflict),
        .store_full   (full),
        .flush_req    (flush_req),
        .ta_clear     (ta_clear),
        .pw_ready     (pw_ready),
        .pw_abort     (pw_abort),
        .push         (push),
        .ta_status    (ta_status)
    );

    pwb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .wr_entry (in_entry),
        .pop      (pop),
        .rd_entry (head),
        .empty    (empty),
        .full     (full)
    );

    pwb_drain u_drain (
        .clk     (clk),
        .rst     (rst),
        .head    (head),
        .empty   (empty),
        .iw_ack  (iw_ack),
        .pop     (pop),
        .iw_req  (iw_req),
        .iw_addr (iw_addr),
        .iw_data (iw_data),
        .iw_be   (iw_be)
    );

    assign flush_done = flush_req && empty && !iw_req;

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker
    import pwb_pkg::*;
#(
    parameter int BUF_BYTES = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  pw_valid,
    input logic [PWB_LANES-1:0]  pw_be,
    input logic                  pw_ready,
    input logic                  pw_abort,
    input logic                  iw_req,
    input logic [PWB_ADDR_W-1:0] iw_addr,
    input logic [PWB_DATA_W-1:0] iw_data,
    input logic [PWB_LANES-1:0]  iw_be,
    input logic                  iw_ack,
    input logic                  flush_req,
    input logic                  flush_done,
    input logic                  ta_status,
    input logic                  ta_clear
);
    localparam int DEPTH = entries_for(BUF_BYTES);
    localparam int CW    = $clog2(DEPTH + 2) + 1;

    logic [CW-1:0] pending;
    logic          posted;
    logic          retired;

    assign posted  = pw_valid && pw_ready && (|pw_be);
    assign retired = iw_req && iw_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else begin
            pending <= pending + CW'(posted) - CW'(retired);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        pending <= CW'(DEPTH + 1)); // R5

    AST_NO_SPURIOUS_REQ: assert property (@(posedge clk) disable iff (rst)
        iw_req |-> pending != '0); // R1

    AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        iw_req && !iw_ack |=> iw_req && $stable(iw_addr) && $stable(iw_data) && $stable(iw_be)); // R3

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush_done |-> flush_req && pending == '0 && !iw_req); // R6

    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> !pw_ready); // R7

    AST_ABORT_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        pw_abort |-> !pw_ready); // R8

    AST_ABORT_SETS: assert property (@(posedge clk) disable iff (rst)
        pw_abort |=> ta_status); // R9

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        ta_status && !ta_clear |=> ta_status); // R9

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ta_status && ta_clear && !pw_abort |=> !ta_status); // R10

endmodule

bind pci_post_wbuf pwb_checker #(.BUF_BYTES(BUF_BYTES)) u_pwb_checker (
    .clk        (clk),
    .rst        (rst),
    .pw_valid   (pw_valid),
    .pw_be      (pw_be),
    .pw_ready   (pw_ready),
    .pw_abort   (pw_abort),
    .iw_req     (iw_req),
    .iw_addr    (iw_addr),
    .iw_data    (iw_data),
    .iw_be      (iw_be),
    .iw_ack     (iw_ack),
    .flush_req  (flush_req),
    .flush_done (flush_done),
    .ta_status  (ta_status),
    .ta_clear   (ta_clear)
);

// File: tb/test_pci_post_wbuf.sv
module test_pci_post_wbuf;
    import pwb_pkg::*;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int BUF_BYTES = 16;
    localparam int DEPTH     = BUF_BYTES / 4;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  pw_frame = 1'b0;
    logic                  pw_valid = 1'b0;
    logic [PWB_ADDR_W-1:0] pw_addr = '0;
    logic [PWB_DATA_W-1:0] pw_data = '0;
    logic [PWB_LANES-1:0]  pw_be = '0;
    logic                  pw_ready;
    logic                  pw_abort;
    logic                  int_conflict = 1'b0;
    logic                  iw_req;
    logic [PWB_ADDR_W-1:0] iw_addr;
    logic [PWB_DATA_W-1:0] iw_data;
    logic [PWB_LANES-1:0]  iw_be;
    logic                  iw_ack = 1'b0;
    logic                  flush_req = 1'b0;
    logic                  flush_done;
    logic                  ta_status;
    logic                  ta_clear = 1'b0;

    int checks = 0;
    int errors = 0;
    int ack_mode = 0;   // 0 never, 1 always, 2 alternate
    int acked = 0;
    int pushed = 0;
    pwb_entry_t expq[$];

    always #2.5 clk = ~clk;

    pci_post_wbuf #(.BUF_BYTES(BUF_BYTES)) i_pci_post_wbuf (
        .clk(clk), .rst(rst), .pw_frame(pw_frame), .pw_valid(pw_valid),
        .pw_addr(pw_addr), .pw_data(pw_data), .pw_be(pw_be),
        .pw_ready(pw_ready), .pw_abort(pw_abort), .int_conflict(int_conflict),
        .iw_req(iw_req), .iw_addr(iw_addr), .iw_data(iw_data), .iw_be(iw_be),
        .iw_ack(iw_ack), .flush_req(flush_req), .flush_done(flush_done),
        .ta_status(ta_status), .ta_clear(ta_clear)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // acknowledge driver
    initial begin
        bit tog = 1'b0;
        forever begin
            @(negedge clk);
            tog = ~tog;
            iw_ack <= (ack_mode == 1) ? 1'b1 : (ack_mode == 2) ? tog : 1'b0;
        end
    end

    // monitor: scoreboard for R1, R2 and stability for R3
    initial begin
        bit          held = 1'b0;
        pwb_entry_t  prev;
        pwb_entry_t  exp;
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                if (held) begin
                    check(iw_req && iw_addr == prev.addr && iw_data == prev.data && iw_be == prev.be,
                          "R3", "held request payload", iw_data, prev.data);
                end
                if (iw_req && iw_ack) begin
                    acked++;
                    if (expq.size() == 0) begin
                        check(1'b0, "R2", "unexpected internal write", iw_addr, 0);
                    end else begin
                        exp = expq.pop_front();
                        check(iw_addr == exp.addr && iw_data == exp.data && iw_be == exp.be,
                              "R1", "write content/order", {iw_addr, iw_data}, {exp.addr, exp.data});
                    end
                end
                held = iw_req && !iw_ack;
                prev = '{addr: iw_addr, data: iw_data, be: iw_be};
            end
        end
    end

    // driver: offer one phase, wait up to limit cycles for acceptance
    task automatic offer(input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, input int limit, output bit acc);
        @(negedge clk);
        pw_frame = 1'b1; pw_valid = 1'b1;
        pw_addr = a; pw_data = d; pw_be = be;
        acc = 1'b0;
        for (int k = 0; k < limit; k++) begin
            #1;
            if (pw_ready) begin
                acc = 1'b1;
                if (be != 4'b0000) begin
                    expq.push_back('{addr: a, data: d, be: be});
                    pushed++;
                end
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic end_frame();
        @(negedge clk);
        pw_valid = 1'b0; pw_frame = 1'b0; int_conflict = 1'b0;
    endtask

    task automatic wait_drained(input string req);
        for (int k = 0; k < 200 && (expq.size() != 0 || iw_req); k++) @(negedge clk);
        #1;
        check(expq.size() == 0 && !iw_req, req, "buffer drained", expq.size(), 0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run hung", 0, 1);
        finish_run();
    end

    initial begin
        bit acc;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        check(!iw_req, "R11", "iw_req after reset", iw_req, 0);
        check(!ta_status, "R11", "ta_status after reset", ta_status, 0);
        check(!flush_done, "R11", "flush_done after reset", flush_done, 0);
        @(negedge clk);
        pw_frame = 1'b1;
        #1;
        check(pw_ready, "R11", "idle ready with frame", pw_ready, 1);

        // burst with always-ack, including a zero-enable phase (R1, R2, R4)
        ack_mode = 1;
        offer(32'h0000_1000, 32'h1111_2222, 4'b1111, 4, acc);
        check(acc, "R1", "burst phase 0 no wait", acc, 1);
        offer(32'h0000_1004, 32'hAAAA_BBBB, 4'b0000, 4, acc);
        check(acc, "R4", "zero-enable phase accepted", acc, 1);
        offer(32'h0000_1008, 32'h3333_4444, 4'b0110, 4, acc);
        offer(32'h0000_100C, 32'h5555_6666, 4'b1000, 4, acc);
        end_frame();
        wait_drained("R2");
        check(acked == 3 && pushed == 3, "R4", "only enabled phases written", acked, 3);

        // alternating acks for ordering and held payload (R2, R3)
        ack_mode = 2;
        for (int i = 0; i < 6; i++) begin
            offer(32'h0000_2000 + 32'(i * 4), 32'hC0DE_0000 + 32'(i), 4'(i + 1), 6, acc);
        end
        end_frame();
        wait_drained("R3");

        // capacity with drain stalled (R5)
        ack_mode = 0;
        n = 0;
        for (int i = 0; i < DEPTH + 3; i++) begin
            offer(32'h0000_3000 + 32'(i * 4), 32'hF00D_0000 + 32'(i), 4'b1111, 3, acc);
            if (acc) n++;
        end
        check(n == DEPTH + 1, "R5", "phases accepted while stalled", n, DEPTH + 1);
        #1;
        check(!pw_ready, "R5", "wait state when full", pw_ready, 0);
        end_frame();
        ack_mode = 1;
        wait_drained("R5");

        // flush ordering (R6, R7, R12)
        ack_mode = 0;
        offer(32'h0000_4000, 32'h0BAD_F00D, 4'b0011, 4, acc);
        offer(32'h0000_4004, 32'h1234_5678, 4'b1100, 4, acc);
        @(negedge clk);
        pw_valid = 1'b0;
        flush_req = 1'b1;
        repeat (4) @(negedge clk);
        pw_valid = 1'b1; pw_addr = 32'h0000_4008; pw_be = 4'b1111;
        #1;
        check(!flush_done, "R6", "no done with writes pending", flush_done, 0);
        check(!pw_ready, "R7", "posting held during flush", pw_ready, 0);
        @(negedge clk);
        pw_valid = 1'b0;
        ack_mode = 1;
        n = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            #1;
            if (flush_done) break;
            n++;
        end
        check(flush_done, "R12", "flush completes after drain", flush_done, 1);
        check(expq.size() == 0, "R6", "all writes acked at done", expq.size(), 0);
        @(negedge clk);
        flush_req = 1'b0;
        #1;
        check(!flush_done, "R6", "done drops with request", flush_done, 0);
        end_frame();

        // abort in the middle of a burst (R8, R9, R10)
        offer(32'h0000_5000, 32'hABCD_0001, 4'b1111, 4, acc);
        check(acc, "R8", "phase before conflict accepted", acc, 1);
        @(negedge clk);
        pw_addr = 32'h0000_5004; pw_data = 32'hABCD_0002; int_conflict = 1'b1;
        #1;
        check(pw_abort && !pw_ready, "R8", "conflict aborts phase", {pw_abort, pw_ready}, 2'b10);
        @(negedge clk);
        int_conflict = 1'b0; pw_addr = 32'h0000_5008;
        #1;
        check(pw_abort && !pw_ready, "R8", "rest of burst aborted", {pw_abort, pw_ready}, 2'b10);
        check(ta_status, "R9", "status set after abort", ta_status, 1);
        end_frame();
        repeat (5) @(negedge clk);
        #1;
        check(ta_status, "R9", "status sticky", ta_status, 1);
        offer(32'h0000_6000, 32'h7777_8888, 4'b0001, 4, acc);
        check(acc && !pw_abort, "R8", "new frame accepted", acc, 1);
        end_frame();
        wait_drained("R8");
        @(negedge clk);
        ta_clear = 1'b1;
        @(negedge clk);
        ta_clear = 1'b0;
        #1;
        check(!ta_status, "R10", "write-one clears status", ta_status, 0);
        // set again, then clear collides with a new abort
        @(negedge clk);
        pw_frame = 1'b1; pw_valid = 1'b1; int_conflict = 1'b1;
        @(negedge clk);
        end_frame();
        @(negedge clk);
        pw_frame = 1'b1; pw_valid = 1'b1; int_conflict = 1'b1; ta_clear = 1'b1;
        @(negedge clk);
        ta_clear = 1'b0;
        pw_valid = 1'b0; pw_frame = 1'b0; int_conflict = 1'b0;
        #1;
        check(ta_status, "R10", "abort wins over clear", ta_status, 1);

        repeat (5) @(negedge clk);
        check(expq.size() == 0, "R2", "no leftover expected writes", expq.size(), 0);
        finish_run();
    end

endmodule